// File: doc/BRIEF.md
# Skew-Clocked Triplicated Counter

This block is a counter whose state register exists three times, each copy on its own clock. The three clocks are one clock delayed by zero, one and two skew steps. Each copy computes its next state from a single held vote. Reset clears the count. A full request loads all ones. Otherwise the count steps up by one, and it rolls over from all ones to zero. A bitwise majority of the three copies gives the result.

The falling edge of the first clock captures that result into a hold register. By then all three skewed edges have passed, so the held value and the count output never show a vote taken between edges. The held value is also the base from which every copy computes its next state. A copy that was corrupted therefore realigns at its next edge.

A transient on the shared full input that is narrower than the skew reaches only one copy, and the vote masks it. An extra edge on one clock, or a reset on one copy, is also masked. Test ports exist for each copy: a stored-bit flip mask, an override of the full request, and a separate reset. A disagreement flag is raised whenever the three copies differ.

Top module: `st_tmr_counter`

## Requirements
- R1: While the reset of all three copies is high at the clock edges, the count output reads zero and the disagreement flag reads zero after the following falling edge of clk_a. Reset takes priority over a full request.
- R2: With full low and no injection, the count output rises by exactly one per clk_a period.
- R3: With full high, the count output becomes all ones (8'hFF at the default width) after the following falling edge of clk_a.
- R4: From all ones with full low, the count rolls over to zero.
- R5: The count output is the bitwise majority of the three copies. When a flip mask corrupts exactly one copy, the count is unchanged and the disagreement flag is 1 for that period.
- R6: Every copy computes its next state from the held vote. A copy corrupted in one period agrees again one period later, so the flag returns to 0 and the count continues correctly.
- R7: A pulse on full_i that is shorter than the skew and covers only the second copy's edge leaves the count on its normal increment. The flag is 1 for that period.
- R8: A full override on one copy, or a reset on one copy alone, changes only that copy. The count is unaffected and the flag is 1 for that period.
- R9: An extra short pulse on the third clock does not change the count output.
- R10: When the same flip mask corrupts two copies in the same period, the count output equals the correct value XOR the mask. Counting then continues from that corrupted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of copy 0; its falling edge captures the vote |
| clk_b | input | 1 | Clock of copy 1, one skew step after clk_a |
| clk_c | input | 1 | Clock of copy 2, two skew steps after clk_a |
| rst_a | input | 1 | Synchronous active-high reset of copy 0 |
| rst_b | input | 1 | Synchronous active-high reset of copy 1 |
| rst_c | input | 1 | Synchronous active-high reset of copy 2 |
| full_i | input | 1 | Load-all-ones request, shared by the copies |
| ovr_en_i | input | 3 | Per-copy enable of the full override (bit k = copy k) |
| ovr_val_i | input | 3 | Per-copy override value of full (bit k = copy k) |
| flip_a_i | input | WIDTH | XOR mask applied to copy 0 at its edge |
| flip_b_i | input | WIDTH | XOR mask applied to copy 1 at its edge |
| flip_c_i | input | WIDTH | XOR mask applied to copy 2 at its edge |
| count_o | output | WIDTH | Held majority value |
| mismatch_o | output | 1 | Registered flag: the copies disagreed at the last capture |

## Verification
A fault on one copy can fall in the same period as the normal update. That update may be an increment, an all-ones load or a rollover, so the vote must mask the fault while the count still moves. The bench provokes each single-copy fault in a period where the golden count changes, then checks both the new count and the disagreement flag after the falling edge of clk_a. The following period is also checked, to see that the faulty copy has realigned. The double fault falls in the same period as an increment, and the golden model takes on the corrupted value from then on.

// File: rtl/st_tmr_pkg.sv
package st_tmr_pkg;
  localparam int unsigned NCOPY = 3;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/st_tmr_copy.sv
module st_tmr_copy #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_i,
  input  logic             ovr_en,
  input  logic             ovr_val,
  input  logic [WIDTH-1:0] flip,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             full_eff;
  logic [WIDTH-1:0] nxt;

  assign full_eff = ovr_en ? ovr_val : full_i;
  assign nxt      = full_eff ? {WIDTH{1'b1}} : held + ONE;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt ^ flip;
  end

  AST_COPY_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_COPY_LOAD: assert property (@(posedge clk) disable iff (rst)
    ((ovr_en ? ovr_val : full_i) && flip == '0) |=> (q == {WIDTH{1'b1}})); // R3
  AST_COPY_STEP: assert property (@(posedge clk) disable iff (rst)
    (!(ovr_en ? ovr_val : full_i) && flip == '0) |=> (q == $past(held) + ONE)); // R2
endmodule

// File: rtl/st_tmr_voter.sv
module st_tmr_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] vote,
  output logic             disagree
);
  import st_tmr_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign vote[i] = maj3(a[i], b[i], c[i]);
  end

  assign disagree = (a != b) || (a != c);
endmodule

// File: rtl/st_tmr_hold.sv
module st_tmr_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vote,
  input  logic             disagree,
  output logic [WIDTH-1:0] held,
  output logic             mism
);
  always_ff @(negedge clk) begin
    if (rst) begin
      held <= '0;
      mism <= 1'b0;
    end else begin
      held <= vote;
      mism <= disagree;
    end
  end
endmodule

// File: rtl/st_tmr_counter.sv
module st_tmr_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             clk_c,
  input  logic             rst_a,
  input  logic             rst_b,
  input  logic             rst_c,
  input  logic             full_i,
  input  logic [2:0]       ovr_en_i,
  input  logic [2:0]       ovr_val_i,
  input  logic [WIDTH-1:0] flip_a_i,
  input  logic [WIDTH-1:0] flip_b_i,
  input  logic [WIDTH-1:0] flip_c_i,
  output logic [WIDTH-1:0] count_o,
  output logic             mismatch_o
);
  import st_tmr_pkg::*;

  logic [NCOPY-1:0]            clk_v;
  logic [NCOPY-1:0]            rst_v;
  logic [NCOPY-1:0][WIDTH-1:0] flip_v;
  logic [NCOPY-1:0][WIDTH-1:0] q_v;
  logic [WIDTH-1:0]            vote;
  logic                        disagree;
  logic                        rst_maj;

  assign clk_v   = {clk_c, clk_b, clk_a};
  assign rst_v   = {rst_c, rst_b, rst_a};
  assign flip_v  = {flip_c_i, flip_b_i, flip_a_i};
  assign rst_maj = maj3(rst_a, rst_b, rst_c);

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    st_tmr_copy #(.WIDTH(WIDTH)) copy_i (
      .clk    (clk_v[k]),
      .rst    (rst_v[k]),
      .full_i (full_i),
      .ovr_en (ovr_en_i[k]),
      .ovr_val(ovr_val_i[k]),
      .flip   (flip_v[k]),
      .held   (count_o),
      .q      (q_v[k])
    );
  end

  st_tmr_voter #(.WIDTH(WIDTH)) voter_i (
    .a       (q_v[0]),
    .b       (q_v[1]),
    .c       (q_v[2]),
    .vote    (vote),
    .disagree(disagree)
  );

  st_tmr_hold #(.WIDTH(WIDTH)) hold_i (
    .clk     (clk_a),
    .rst     (rst_maj),
    .vote    (vote),
    .disagree(disagree),
    .held    (count_o),
    .mism    (mismatch_o)
  );

  AST_VOTE_AB: assert property (@(negedge clk_a) disable iff (rst_maj)
    (q_v[0] == q_v[1]) |=> (count_o == $past(q_v[0]))); // R5
  AST_VOTE_BC: assert property (@(negedge clk_a) disable iff (rst_maj)
    (q_v[1] == q_v[2]) |=> (count_o == $past(q_v[1]))); // R5
  AST_FLAG_SET: assert property (@(negedge clk_a) disable iff (rst_maj)
    (q_v[0] != q_v[2]) |=> mismatch_o); // R5
  AST_FLAG_CLR: assert property (@(negedge clk_a) disable iff (rst_maj)
    (q_v[0] == q_v[1] && q_v[1] == q_v[2]) |=> !mismatch_o); // R6
endmodule

// File: tb/st_tmr_counter_tb_top.sv
`timescale 1ns/100ps
module st_tmr_counter_tb_top;
  localparam int unsigned W = 8;

  logic clk_a = 1'b0, clk_b = 1'b0, clk_c_base = 1'b0, clk_glitch = 1'b0;
  logic clk_c;
  logic rst_a = 1'b0, rst_b = 1'b0, rst_c = 1'b0, full_i = 1'b0;
  logic [2:0] ovr_en = '0, ovr_val = '0;
  logic [W-1:0] flip_a = '0, flip_b = '0, flip_c = '0;
  logic [W-1:0] count_o;
  logic mismatch_o;

  int n_checks = 0, n_errors = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  bit mism_q[$];
  string tag_q[$];
  bit done = 0;

  assign clk_c = clk_c_base | clk_glitch;

  initial forever #2.5 clk_a = ~clk_a;
  initial begin #1; forever #2.5 clk_b = ~clk_b; end
  initial begin #2; forever #2.5 clk_c_base = ~clk_c_base; end

  st_tmr_counter #(.WIDTH(W)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c),
    .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c),
    .full_i(full_i), .ovr_en_i(ovr_en), .ovr_val_i(ovr_val),
    .flip_a_i(flip_a), .flip_b_i(flip_b), .flip_c_i(flip_c),
    .count_o(count_o), .mismatch_o(mismatch_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 flip copy1, 2 full override copy2, 3 reset copy1 only,
  // 4 narrow full_i pulse at copy1 edge, 5 extra clk_c pulse, 6 flip copies 0 and 1
  task automatic step(input bit full, input bit rst, input int kind,
                      input logic [W-1:0] mask, input string tag);
    bit em;
    @(negedge clk_a); #1;
    flip_a = '0; flip_b = '0; flip_c = '0; ovr_en = '0; ovr_val = '0;
    full_i = full; rst_a = rst; rst_b = rst; rst_c = rst;
    em = 1'b0;
    case (kind)
      1: begin flip_b = mask; em = 1'b1; end
      2: begin ovr_en = 3'b100; ovr_val = 3'b100; em = 1'b1; end
      3: begin rst_b = 1'b1; em = 1'b1; end
      4: begin
        em = 1'b1;
        fork begin @(posedge clk_a); #0.8; full_i = 1'b1; #0.4; full_i = 1'b0; end join_none
      end
      5: fork begin @(posedge clk_a); #0.3; clk_glitch = 1'b1; #0.3; clk_glitch = 1'b0; end join_none
      6: begin flip_a = mask; flip_b = mask; em = 1'b1; end
      default: ;
    endcase
    if (rst) model = '0;
    else if (full) model = '1;
    else model = model + 1'b1;
    if (kind == 6) model = model ^ mask;
    exp_q.push_back(model);
    mism_q.push_back(em);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk_a) begin
    #0.5;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      bit m;
      string t;
      e = exp_q.pop_front();
      m = mism_q.pop_front();
      t = tag_q.pop_front();
      check(count_o === e, {t, " count"}, int'(count_o), int'(e));
      check(mismatch_o === m, {t, " flag"}, int'(mismatch_o), int'(m));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    step(0, 1, 0, '0, "R1 reset");
    step(0, 1, 0, '0, "R1 reset hold");
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, "R2 increment");
    step(1, 0, 0, '0, "R3 full load");
    step(1, 1, 0, '0, "R1 reset over full");
    step(0, 0, 0, '0, "R2 after reset");
    step(1, 0, 0, '0, "R3 full again");
    step(0, 0, 0, '0, "R4 rollover");
    step(0, 0, 0, '0, "R4 after rollover");
    step(0, 0, 1, 8'h5A, "R5 single flip");
    step(0, 0, 0, '0, "R6 realign after flip");
    step(1, 0, 1, 8'h81, "R5 flip during full");
    step(0, 0, 0, '0, "R6 rollover after flip");
    step(0, 0, 2, '0, "R8 override copy2");
    step(0, 0, 0, '0, "R6 realign after override");
    step(0, 0, 3, '0, "R8 reset copy1 alone");
    step(0, 0, 0, '0, "R6 realign after copy reset");
    step(0, 0, 4, '0, "R7 narrow full pulse");
    step(0, 0, 0, '0, "R6 realign after pulse");
    step(0, 0, 5, '0, "R9 clock glitch");
    step(0, 0, 0, '0, "R9 after clock glitch");
    step(0, 0, 6, 8'h0F, "R10 double flip");
    step(0, 0, 0, '0, "R10 continue from corrupt");
    step(0, 0, 0, '0, "R10 continue again");
    step(0, 1, 0, '0, "R1 final reset");
    @(negedge clk_a);
    @(negedge clk_a);
    #2;
    finish_run();
  end
endmodule